// File: doc/BRIEF.md
# Prioritized Interrupt Level Dispatcher

This block decides, one request at a time, whether a pending interrupt level is taken. It also produces the state a processor needs on entry to the handler. A request carries a level number. The block compares that level with the interrupt-level field of the current status word and with the configured number of levels. It then checks whether any interrupt line routed to that level is both set and enabled. When the request is accepted, the block produces a new PC (the handler vector), a new status word, a single-cycle taken strobe and a code naming the kind of entry taken.

Levels above 1 are high-priority entries. Each of these levels has its own save-PC register, its own save-status register and its own vector. Level 1 is handled differently and becomes a general exception. The cause register is loaded with the level-1 interrupt code, and the entry is a user, kernel or double exception, chosen by the exception-mode and user-mode bits of the status word. All vectors may be relocated through a vector-base input. Every result is registered, so a core sees the dispatch outcome one clock after it presents the request.

Top module: `irq_level_dispatch`

## Requirements
- R1: A request (req_valid high) is accepted only when all three conditions hold: req_level is greater than status bits [3:0], req_level is no greater than NUM_LEVELS, and the mask of that level ANDed with irq_set and irq_en is nonzero. The level's mask is the slice lvl_mask_flat[L*NUM_IRQ +: NUM_IRQ]. An accepted request raises taken in the following cycle.
- R2: When a level L of 2 or more is taken, the PC input is stored in save-PC slot L and the status input in save-status slot L. Save-PC slot L is epc_flat[(L-1)*AW +: AW], and save-status slot L is eps_flat[(L-2)*AW +: AW].
- R3: When a level L of 2 or more is taken, ps_out equals the status input with bits [3:0] replaced by L and bit 4 (exception mode) set. All other bits are kept.
- R4: When level 1 is taken, exccause_out is loaded with L1_CAUSE (default 4). No other event changes exccause_out.
- R5: When level 1 is taken with status bit 4 set, the entry is a double exception (kind 4) and the PC is stored in depc_out. This applies when HAS_DEPC is nonzero; otherwise the PC goes to save-PC slot 1. The vector is at offset DBL_OFS.
- R6: When level 1 is taken with status bit 4 clear, the PC is stored in save-PC slot 1. The entry is user (kind 3, offset USR_OFS) if status bit 5 is set, and kernel (kind 2, offset KRN_OFS) otherwise. ps_out is the status input with bit 4 set.
- R7: The fixed vector is DEF_BASE plus the offset. For a high level L, the offset is HI_OFS + (L-2)*HI_STRIDE. With RELOC_EN set, pc_out is the fixed vector minus DEF_BASE plus vec_base; with RELOC_EN clear, pc_out is the fixed vector. A high-level take reports kind 1.
- R8: taken is high for exactly one cycle per accepted request. A request presented in a cycle where taken is high is ignored.
- R9: A cycle with no accepted request changes none of pc_out, ps_out, kind_out, exccause_out, the save registers or depc_out. Save slots of levels other than the taken one keep their values.
- R10: While rst is high, every output is zero. kind 0 means no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A pending level is presented this cycle |
| req_level | input | LW | Pending interrupt level |
| irq_set | input | NUM_IRQ | Raised interrupt lines |
| irq_en | input | NUM_IRQ | Enabled interrupt lines |
| lvl_mask_flat | input | (NUM_LEVELS+1)*NUM_IRQ | Per-level line masks, slice L for level L |
| ps_in | input | AW | Current status word |
| pc_in | input | AW | Current PC |
| vec_base | input | AW | Vector-base register value |
| pc_out | output | AW | Handler vector of the last entry |
| ps_out | output | AW | Status word after the last entry |
| epc_flat | output | NUM_LEVELS*AW | Save-PC slots, levels 1..NUM_LEVELS |
| eps_flat | output | (NUM_LEVELS-1)*AW | Save-status slots, levels 2..NUM_LEVELS |
| depc_out | output | AW | Double-exception save PC |
| exccause_out | output | CW | Exception cause |
| kind_out | output | 3 | Entry kind: 0 none, 1 high, 2 kernel, 3 user, 4 double |
| taken | output | 1 | One-cycle strobe for an accepted request |

## Verification
Every result of a request sampled at clock edge k appears in the registers updated at edge k itself. This covers the taken strobe, the vector, the new status word, the cause and the save slot. A request that arrives while taken is high is dropped at that same edge. The bench's reference model therefore advances at each rising edge from the inputs it sees there, and all outputs are compared with the model a short time after that edge, once the registers have settled. Directed requests are driven on the falling edge and checked against literal values on the next falling edge, one full register stage later.

// File: rtl/irq_disp_pkg.sv
`timescale 1ns/1ps
package irq_disp_pkg;
  // Entry kinds reported on kind_out
  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_HIGH   = 3'd1,
    KIND_KERNEL = 3'd2,
    KIND_USER   = 3'd3,
    KIND_DOUBLE = 3'd4
  } take_kind_e;

  // Status word field positions decoded by the core
  localparam int PS_LVL_LSB  = 0;
  localparam int PS_LVL_W    = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
endpackage

// File: rtl/irq_level_qualify.sv
`timescale 1ns/1ps
module irq_level_qualify #(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_LEVELS = 6,
  parameter int LW         = 3
) (
  input  logic                              req_valid,
  input  logic                              hold_off,
  input  logic [LW-1:0]                     req_level,
  input  logic [irq_disp_pkg::PS_LVL_W-1:0] cur_level,
  input  logic [NUM_IRQ-1:0]                irq_set,
  input  logic [NUM_IRQ-1:0]                irq_en,
  input  logic [(NUM_LEVELS+1)*NUM_IRQ-1:0] lvl_mask_flat,
  output logic                              accept
);
  localparam int SLOTS = 1 << LW;
  localparam int CMP_W = (LW > irq_disp_pkg::PS_LVL_W) ? LW + 1 : irq_disp_pkg::PS_LVL_W + 1;

  logic [NUM_IRQ-1:0] live;
  logic [SLOTS-1:0]   lvl_hit;
  logic [CMP_W-1:0]   lvl_ext, cur_ext;

  assign live = irq_set & irq_en;

  for (genvar g = 0; g < SLOTS; g++) begin : g_hit
    if (g <= NUM_LEVELS) begin : g_real
      assign lvl_hit[g] = |(lvl_mask_flat[g*NUM_IRQ +: NUM_IRQ] & live);
    end else begin : g_none
      assign lvl_hit[g] = 1'b0;
    end
  end

  assign lvl_ext = CMP_W'(req_level);
  assign cur_ext = CMP_W'(cur_level);

  always_comb begin
    accept = 1'b0;
    if (req_valid && !hold_off && (lvl_ext > cur_ext) &&
        (lvl_ext <= CMP_W'(NUM_LEVELS)) && lvl_hit[req_level])
      accept = 1'b1;
  end
endmodule

// File: rtl/irq_vector_sel.sv
`timescale 1ns/1ps
module irq_vector_sel
  import irq_disp_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            LW        = 3,
  parameter bit            RELOC_EN  = 1'b1,
  parameter logic [AW-1:0] DEF_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0] KRN_OFS   = 32'h0000_0300,
  parameter logic [AW-1:0] USR_OFS   = 32'h0000_0340,
  parameter logic [AW-1:0] DBL_OFS   = 32'h0000_03C0,
  parameter logic [AW-1:0] HI_OFS    = 32'h0000_0180,
  parameter logic [AW-1:0] HI_STRIDE = 32'h0000_0040
) (
  input  logic [LW-1:0] level,
  input  logic          excm,
  input  logic          um,
  input  logic [AW-1:0] vec_base,
  output take_kind_e    kind,
  output logic [AW-1:0] target
);
  logic [AW-1:0] ofs, fixed_vec;

  always_comb begin
    kind = KIND_HIGH;
    ofs  = HI_OFS + HI_STRIDE * (AW'(level) - AW'(2));
    if (level == LW'(1)) begin
      if (excm) begin
        kind = KIND_DOUBLE;
        ofs  = DBL_OFS;
      end else if (um) begin
        kind = KIND_USER;
        ofs  = USR_OFS;
      end else begin
        kind = KIND_KERNEL;
        ofs  = KRN_OFS;
      end
    end
  end

  assign fixed_vec = DEF_BASE + ofs;

  if (RELOC_EN) begin : g_reloc
    assign target = fixed_vec - DEF_BASE + vec_base;
  end else begin : g_fixed
    logic unused_base;
    assign unused_base = ^vec_base;
    assign target = fixed_vec;
  end
endmodule

// File: rtl/irq_save_bank.sv
`timescale 1ns/1ps
module irq_save_bank #(
  parameter int AW         = 32,
  parameter int NUM_LEVELS = 6,
  parameter int LW         = 3,
  parameter bit HAS_DEPC   = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [LW-1:0]              level,
  input  logic                       is_double,
  input  logic [AW-1:0]              pc_in,
  input  logic [AW-1:0]              ps_in,
  output logic [NUM_LEVELS*AW-1:0]   epc_flat,
  output logic [(NUM_LEVELS-1)*AW-1:0] eps_flat,
  output logic [AW-1:0]              depc_out
);
  // Save-PC slots, one per level
  for (genvar g = 1; g <= NUM_LEVELS; g++) begin : g_epc
    logic [AW-1:0] r;
    logic          wr;
    if (g == 1) begin : g_l1
      assign wr = we && (level == LW'(1)) && !(is_double && HAS_DEPC);
    end else begin : g_hi
      assign wr = we && (level == LW'(g));
    end
    always_ff @(posedge clk) begin
      if (rst)     r <= '0;
      else if (wr) r <= pc_in;
    end
    assign epc_flat[(g-1)*AW +: AW] = r;
  end

  // Save-status slots, high levels only
  for (genvar g = 2; g <= NUM_LEVELS; g++) begin : g_eps
    logic [AW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                            r <= '0;
      else if (we && (level == LW'(g)))   r <= ps_in;
    end
    assign eps_flat[(g-2)*AW +: AW] = r;
  end

  if (HAS_DEPC) begin : g_depc
    logic [AW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                                        r <= '0;
      else if (we && is_double && level == LW'(1))    r <= pc_in;
    end
    assign depc_out = r;
  end else begin : g_no_depc
    assign depc_out = '0;
  end
endmodule

// File: rtl/irq_level_dispatch.sv
`timescale 1ns/1ps
module irq_level_dispatch
  import irq_disp_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            NUM_IRQ    = 32,
  parameter int            NUM_LEVELS = 6,
  parameter int            CW         = 6,
  parameter logic [CW-1:0] L1_CAUSE   = 6'd4,
  parameter bit            HAS_DEPC   = 1'b1,
  parameter bit            RELOC_EN   = 1'b1,
  parameter logic [AW-1:0] DEF_BASE   = 32'h4000_0000,
  parameter logic [AW-1:0] KRN_OFS    = 32'h0000_0300,
  parameter logic [AW-1:0] USR_OFS    = 32'h0000_0340,
  parameter logic [AW-1:0] DBL_OFS    = 32'h0000_03C0,
  parameter logic [AW-1:0] HI_OFS     = 32'h0000_0180,
  parameter logic [AW-1:0] HI_STRIDE  = 32'h0000_0040,
  localparam int           LW         = $clog2(NUM_LEVELS + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [LW-1:0]                     req_level,
  input  logic [NUM_IRQ-1:0]                irq_set,
  input  logic [NUM_IRQ-1:0]                irq_en,
  input  logic [(NUM_LEVELS+1)*NUM_IRQ-1:0] lvl_mask_flat,
  input  logic [AW-1:0]                     ps_in,
  input  logic [AW-1:0]                     pc_in,
  input  logic [AW-1:0]                     vec_base,
  output logic [AW-1:0]                     pc_out,
  output logic [AW-1:0]                     ps_out,
  output logic [NUM_LEVELS*AW-1:0]          epc_flat,
  output logic [(NUM_LEVELS-1)*AW-1:0]      eps_flat,
  output logic [AW-1:0]                     depc_out,
  output logic [CW-1:0]                     exccause_out,
  output logic [2:0]                        kind_out,
  output logic                              taken
);
  logic          accept;
  take_kind_e    kind_nx;
  logic [AW-1:0] target;
  logic [AW-1:0] ps_nx;
  logic          taken_q;

  irq_level_qualify #(
    .NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS), .LW(LW)
  ) u_qual (
    .req_valid    (req_valid),
    .hold_off     (taken_q),
    .req_level    (req_level),
    .cur_level    (ps_in[PS_LVL_LSB +: PS_LVL_W]),
    .irq_set      (irq_set),
    .irq_en       (irq_en),
    .lvl_mask_flat(lvl_mask_flat),
    .accept       (accept)
  );

  irq_vector_sel #(
    .AW(AW), .LW(LW), .RELOC_EN(RELOC_EN), .DEF_BASE(DEF_BASE),
    .KRN_OFS(KRN_OFS), .USR_OFS(USR_OFS), .DBL_OFS(DBL_OFS),
    .HI_OFS(HI_OFS), .HI_STRIDE(HI_STRIDE)
  ) u_vec (
    .level   (req_level),
    .excm    (ps_in[PS_EXCM_BIT]),
    .um      (ps_in[PS_UM_BIT]),
    .vec_base(vec_base),
    .kind    (kind_nx),
    .target  (target)
  );

  irq_save_bank #(
    .AW(AW), .NUM_LEVELS(NUM_LEVELS), .LW(LW), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (accept),
    .level    (req_level),
    .is_double(kind_nx == KIND_DOUBLE),
    .pc_in    (pc_in),
    .ps_in    (ps_in),
    .epc_flat (epc_flat),
    .eps_flat (eps_flat),
    .depc_out (depc_out)
  );

  // New status word: high levels raise the level field, all set exception mode
  always_comb begin
    ps_nx = ps_in;
    ps_nx[PS_EXCM_BIT] = 1'b1;
    if (kind_nx == KIND_HIGH)
      ps_nx[PS_LVL_LSB +: PS_LVL_W] = PS_LVL_W'(req_level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q      <= 1'b0;
      pc_out       <= '0;
      ps_out       <= '0;
      kind_out     <= KIND_NONE;
      exccause_out <= '0;
    end else begin
      taken_q <= accept;
      if (accept) begin
        pc_out   <= target;
        ps_out   <= ps_nx;
        kind_out <= kind_nx;
        if (kind_nx != KIND_HIGH)
          exccause_out <= L1_CAUSE;
      end
    end
  end

  assign taken = taken_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
`timescale 1ns/1ps
module irq_dispatch_chk
  import irq_disp_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            NUM_LEVELS = 6,
  parameter int            LW         = 3,
  parameter int            CW         = 6,
  parameter logic [CW-1:0] L1_CAUSE   = 6'd4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [LW-1:0]                req_level,
  input logic [AW-1:0]                ps_in,
  input logic [AW-1:0]                ps_out,
  input logic [NUM_LEVELS*AW-1:0]     epc_flat,
  input logic [(NUM_LEVELS-1)*AW-1:0] eps_flat,
  input logic [AW-1:0]                depc_out,
  input logic [CW-1:0]                exccause_out,
  input logic [2:0]                   kind_out,
  input logic                         taken
);
  assert_taken_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    taken |=> !taken);

  assert_level_range_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_level > LW'(NUM_LEVELS))) |=> !taken);

  assert_high_ps_R3: assert property (@(posedge clk) disable iff (rst)
    (taken && kind_out == KIND_HIGH) |->
      (ps_out[PS_LVL_LSB +: PS_LVL_W] == PS_LVL_W'($past(req_level)) && ps_out[PS_EXCM_BIT]));

  assert_l1_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (taken && (kind_out == KIND_USER || kind_out == KIND_KERNEL || kind_out == KIND_DOUBLE))
      |-> exccause_out == L1_CAUSE);

  assert_double_excm_R5: assert property (@(posedge clk) disable iff (rst)
    (taken && kind_out == KIND_DOUBLE) |-> $past(ps_in[PS_EXCM_BIT]));

  assert_save_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !taken |-> ($stable(epc_flat) && $stable(eps_flat) && $stable(depc_out)));
endmodule

bind irq_level_dispatch irq_dispatch_chk #(
  .AW(AW), .NUM_LEVELS(NUM_LEVELS), .LW(LW), .CW(CW), .L1_CAUSE(L1_CAUSE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
  .ps_in(ps_in), .ps_out(ps_out), .epc_flat(epc_flat), .eps_flat(eps_flat),
  .depc_out(depc_out), .exccause_out(exccause_out), .kind_out(kind_out),
  .taken(taken)
);

// File: tb/tb_irq_level_dispatch.sv
`timescale 1ns/1ps
module tb_irq_level_dispatch;
  localparam int NL = 6;
  localparam int NI = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_level = '0;
  logic [31:0] irq_set = '0, irq_en = '0, ps_in = '0, pc_in = '0, vec_base = '0;
  logic [(NL+1)*NI-1:0] lvl_mask_flat;
  logic [31:0] pc_out, ps_out, depc_out;
  logic [NL*32-1:0] epc_flat;
  logic [(NL-1)*32-1:0] eps_flat;
  logic [5:0] exccause_out;
  logic [2:0] kind_out;
  logic taken;

  logic [31:0] lvl_mask [0:7];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  initial begin
    for (int l = 0; l < 8; l++)
      lvl_mask[l] = (l >= 1 && l <= NL) ? (32'h0000_000F << (4 * l)) : 32'h0;
  end

  always_comb begin
    for (int l = 0; l <= NL; l++) lvl_mask_flat[l*NI +: NI] = lvl_mask[l];
  end

  irq_level_dispatch dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .irq_set(irq_set), .irq_en(irq_en), .lvl_mask_flat(lvl_mask_flat),
    .ps_in(ps_in), .pc_in(pc_in), .vec_base(vec_base),
    .pc_out(pc_out), .ps_out(ps_out), .epc_flat(epc_flat), .eps_flat(eps_flat),
    .depc_out(depc_out), .exccause_out(exccause_out), .kind_out(kind_out),
    .taken(taken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_epc [1:NL];
  logic [31:0] m_eps [2:NL];
  logic [31:0] m_depc, m_pc, m_ps;
  logic [5:0]  m_cause;
  logic [2:0]  m_kind;
  bit          m_taken;
  int          m_lv;
  bit          m_ok;

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 1; l <= NL; l++) m_epc[l] = '0;
      for (int l = 2; l <= NL; l++) m_eps[l] = '0;
      m_depc = '0; m_pc = '0; m_ps = '0; m_cause = '0; m_kind = 3'd0; m_taken = 0;
    end else begin
      m_lv = int'(req_level);
      m_ok = req_valid && !m_taken && (m_lv > int'(ps_in[3:0])) && (m_lv <= NL) &&
             ((lvl_mask[m_lv] & irq_set & irq_en) != 32'h0);
      m_taken = m_ok;
      if (m_ok) begin
        if (m_lv >= 2) begin
          m_epc[m_lv] = pc_in;
          m_eps[m_lv] = ps_in;
          m_ps   = {ps_in[31:5], 1'b1, 4'(m_lv)};
          m_pc   = vec_base + 32'h180 + 32'h40 * (m_lv - 2);
          m_kind = 3'd1;
        end else begin
          m_cause = 6'd4;
          if (ps_in[4]) begin
            m_depc = pc_in;
            m_kind = 3'd4;
            m_pc   = vec_base + 32'h3C0;
          end else begin
            m_epc[1] = pc_in;
            m_kind = ps_in[5] ? 3'd3 : 3'd2;
            m_pc   = vec_base + (ps_in[5] ? 32'h340 : 32'h300);
          end
          m_ps = ps_in | 32'h10;
        end
      end
    end
    #2;
    chk("R1/R8 taken", 32'(taken), 32'(m_taken));
    chk("R7 pc_out", pc_out, m_pc);
    chk("R3/R6 ps_out", ps_out, m_ps);
    chk("R6 kind_out", 32'(kind_out), 32'(m_kind));
    chk("R4 exccause", 32'(exccause_out), 32'(m_cause));
    chk("R5 depc", depc_out, m_depc);
    for (int l = 1; l <= NL; l++) chk("R2/R9 epc", epc_flat[(l-1)*32 +: 32], m_epc[l]);
    for (int l = 2; l <= NL; l++) chk("R2/R9 eps", eps_flat[(l-2)*32 +: 32], m_eps[l]);
  end

  task automatic req(input logic [2:0] lv, input logic [31:0] s, input logic [31:0] e,
                     input logic [31:0] ps, input logic [31:0] pc);
    req_valid = 1'b1; req_level = lv; irq_set = s; irq_en = e; ps_in = ps; pc_in = pc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    vec_base = 32'h6000_0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset pc", pc_out, 32'h0);
    chk("R10 reset taken", 32'(taken), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R7: high level 3
    req(3'd3, 32'h0000_F000, 32'h0000_F000, 32'h0000_0021, 32'h1234_5678);
    chk("R1 taken level3", 32'(taken), 32'h1);
    chk("R7 vector level3", pc_out, 32'h6000_01C0);
    chk("R3 ps level3", ps_out, 32'h0000_0033);
    chk("R2 epc3", epc_flat[2*32 +: 32], 32'h1234_5678);
    chk("R2 eps3", eps_flat[1*32 +: 32], 32'h0000_0021);
    @(negedge clk);
    chk("R8 taken drops", 32'(taken), 32'h0);

    // R1: level not above current
    req(3'd3, 32'h0000_F000, 32'h0000_F000, 32'h0000_0003, 32'hAAAA_0000);
    chk("R1 reject current level", 32'(taken), 32'h0);
    chk("R9 epc3 kept", epc_flat[2*32 +: 32], 32'h1234_5678);
    // R1: level beyond configured
    req(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hBBBB_0000);
    chk("R1 reject level7", 32'(taken), 32'h0);
    // R1: nothing enabled
    req(3'd2, 32'h0000_0F00, 32'h0000_0000, 32'h0, 32'hCCCC_0000);
    chk("R1 reject disabled", 32'(taken), 32'h0);
    chk("R9 pc kept", pc_out, 32'h6000_01C0);

    // R6 user
    req(3'd1, 32'h0000_00F0, 32'h0000_0010, 32'h0000_0020, 32'h0000_1000);
    chk("R6 user kind", 32'(kind_out), 32'd3);
    chk("R6 user vector", pc_out, 32'h6000_0340);
    chk("R6 user ps", ps_out, 32'h0000_0030);
    chk("R6 epc1", epc_flat[0 +: 32], 32'h0000_1000);
    chk("R4 cause", 32'(exccause_out), 32'd4);
    @(negedge clk);
    // R6 kernel
    req(3'd1, 32'h0000_0020, 32'h0000_0020, 32'h0000_0000, 32'h0000_2000);
    chk("R6 kernel kind", 32'(kind_out), 32'd2);
    chk("R6 kernel vector", pc_out, 32'h6000_0300);
    @(negedge clk);
    // R5 double
    req(3'd1, 32'h0000_0040, 32'h0000_0040, 32'h0000_0010, 32'h0000_3000);
    chk("R5 double kind", 32'(kind_out), 32'd4);
    chk("R5 double vector", pc_out, 32'h6000_03C0);
    chk("R5 depc", depc_out, 32'h0000_3000);
    chk("R5 epc1 kept", epc_flat[0 +: 32], 32'h0000_2000);
    @(negedge clk);

    // R8: back-to-back requests, second ignored
    req(3'd5, 32'h00F0_0000, 32'h00F0_0000, 32'h0, 32'h0000_5000);
    chk("R8 first taken", 32'(taken), 32'h1);
    req(3'd6, 32'h0F00_0000, 32'h0F00_0000, 32'h0, 32'h0000_6000);
    chk("R8 second ignored", 32'(taken), 32'h0);
    chk("R8 epc6 kept", epc_flat[5*32 +: 32], 32'h0);
    chk("R7 vector level5", pc_out, 32'h6000_0240);

    // Pseudo-random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      req_valid = ($urandom % 2) == 0;
      req_level = 3'($urandom);
      irq_set   = $urandom;
      irq_en    = $urandom;
      ps_in     = $urandom & 32'hFFFF_FFF7;
      pc_in     = $urandom;
      vec_base  = $urandom & 32'hFFFF_F000;
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule